// File: doc/BRIEF.md
# Buffered Serial-Peripheral Master

This block is a master-only synchronous serial engine built on the datapath of a UART. Software writes a byte through a single-cycle write strobe. The byte waits in a holding register until the shift register is free, and is then sent out on `mosi`. At the same time, bits arriving on `miso` are gathered into a byte. The engine always drives the clock, so a byte must be written even when only receiving, because the write is what starts the clock.

A 12-bit divider sets the serial clock rate. Three static settings choose the clock idle level, which edge samples data, and the bit order. Received bytes go into a two-entry queue that is read by a pop strobe. Three flags report state: the holding register can take a byte, every accepted byte has been sent, and received data is waiting. The receiver can be turned off while the transmitter keeps clocking frames. The receive error outputs exist for register compatibility and are always zero. The block has no slave-select output, no collision detection and no special fast mode. The only way to speed up the clock is to lower the divider value.

Top module: `usart_spi_master`

## Requirements
- R1: After reset, `flag_dre`=1, `flag_txc`=0, `flag_rxc`=0, and `sck` equals `cfg_cpol`.
- R2: A write is accepted only while `cfg_tx_en`=1. A write made while the transmitter is disabled is dropped: `sck` does not toggle, `flag_dre` stays 1, and enabling the transmitter later starts no frame.
- R3: `sck` rests at `cfg_cpol` between frames. Each half period lasts `cfg_baud`+1 clocks, and a frame has exactly 16 `sck` transitions. Count from the clock edge that accepts a write made while the engine is idle. `flag_txc` becomes 1 on the (16·(`cfg_baud`+1)+1)-th edge after that edge.
- R4: With `cfg_cpha`=0, the engine samples `miso` on the leading edge (the transition away from idle) and changes `mosi` on the trailing edge. The first bit is valid before the first edge. With `cfg_cpha`=1, the engine changes `mosi` on the leading edge and samples on the trailing edge.
- R5: With `cfg_lsb_first`=1, bit 0 is shifted first in both directions. With `cfg_lsb_first`=0, bit 7 is shifted first.
- R6: `flag_dre` is 1 while the holding register is empty. A write accepted while the engine is busy waits there and is sent as the next frame. A write made while the holding register is full is dropped.
- R7: `flag_txc` is set when a frame ends and the holding register is empty. It is not set at the end of a frame that has a byte queued behind it. A one-cycle pulse on `txc_clr` clears it.
- R8: Received bytes enter a two-entry queue. `rd_data` shows the oldest byte, and `flag_rxc` is 1 while the queue is not empty. `rd_en` removes the oldest byte. A frame that ends while both entries are full is discarded.
- R9: With `cfg_rx_en`=0, frames are still clocked and transmitted, but no byte enters the receive queue.
- R10: `err_flags` (frame, overrun, parity) always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tx_en | input | 1 | Transmitter enable; needed for any transfer |
| cfg_rx_en | input | 1 | Receiver enable |
| cfg_cpol | input | 1 | Idle level of `sck` |
| cfg_cpha | input | 1 | Sampling edge select (0 leading, 1 trailing) |
| cfg_lsb_first | input | 1 | Bit order, 1 = LSB first |
| cfg_baud | input | 12 | Half-period length minus one, in clocks |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Pop strobe for the receive queue |
| rd_data | output | 8 | Oldest received byte |
| txc_clr | input | 1 | Clear strobe for `flag_txc` |
| flag_dre | output | 1 | Holding register can accept a byte |
| flag_txc | output | 1 | All accepted bytes have been sent |
| flag_rxc | output | 1 | Received data is waiting |
| err_flags | output | 3 | Receive error flags, tied to zero |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions assume that `cfg_cpol`, `cfg_cpha`, `cfg_lsb_first` and `cfg_baud` do not change while a frame is being shifted. Under that assumption, a stable `sck` between divider ticks reflects the engine and not a changed setting. The stimulus meets this assumption: every mode change happens only after `flag_txc` shows the engine is idle, and it is followed by a spare clock before the next write. The bench models a slave device that follows the selected phase and order. It presents each `miso` bit at least one half period before the sampling edge, so the engine never samples a bit that is changing.

// File: rtl/usart_spi_master.sv
module usart_spi_master #(
  parameter int BAUD_W  = 12,
  parameter int FRAME_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_tx_en,
  input  logic              cfg_rx_en,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic [BAUD_W-1:0] cfg_baud,
  input  logic              wr_en,
  input  logic [FRAME_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [FRAME_W-1:0] rd_data,
  input  logic              txc_clr,
  output logic              flag_dre,
  output logic              flag_txc,
  output logic              flag_rxc,
  output logic [2:0]        err_flags,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  localparam int EDGES = 2 * FRAME_W;
  localparam int EW    = $clog2(EDGES);

  logic [FRAME_W-1:0] tx_buf, tx_sh, rx_sh, rx_q0, rx_q1;
  logic               tx_full, busy, sck_ph, txc_q;
  logic [1:0]         rx_cnt;
  logic [BAUD_W-1:0]  cnt;
  logic [EW-1:0]      edge_no;

  wire tick   = busy && (cnt == cfg_baud);
  wire lead   = ~edge_no[0];
  wire last   = (edge_no == EW'(EDGES - 1));
  wire first  = (edge_no == '0);
  wire smp    = tick && (lead ^ cfg_cpha);
  wire shf    = tick && !(lead ^ cfg_cpha) && !(cfg_cpha ? first : last);
  wire done   = tick && last;
  wire load   = !busy && tx_full;
  wire wr_ok  = wr_en && cfg_tx_en && (!tx_full || load);
  wire rx_push = done && cfg_rx_en;
  wire pop    = rd_en && (rx_cnt != 2'd0);
  wire push_ok = rx_push && ((rx_cnt != 2'd2) || pop);

  logic [FRAME_W-1:0] rx_nx;
  always_comb begin
    rx_nx = rx_sh;
    if (smp)
      rx_nx = cfg_lsb_first ? {miso, rx_sh[FRAME_W-1:1]} : {rx_sh[FRAME_W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_buf  <= '0;
    end else begin
      if (wr_ok) begin
        tx_full <= 1'b1;
        tx_buf  <= wr_data;
      end else if (load) begin
        tx_full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      edge_no <= '0;
      sck_ph  <= 1'b0;
      tx_sh   <= '0;
      rx_sh   <= '0;
    end else if (load) begin
      busy    <= 1'b1;
      cnt     <= '0;
      edge_no <= '0;
      sck_ph  <= 1'b0;
      tx_sh   <= tx_buf;
    end else if (busy) begin
      rx_sh <= rx_nx;
      if (tick) begin
        cnt     <= '0;
        edge_no <= edge_no + 1'b1;
        sck_ph  <= ~sck_ph;
        if (done) busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (shf)
        tx_sh <= cfg_lsb_first ? (tx_sh >> 1) : (tx_sh << 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      txc_q <= 1'b0;
    else if (done && !tx_full)
      txc_q <= 1'b1;
    else if (txc_clr)
      txc_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cnt <= 2'd0;
      rx_q0  <= '0;
      rx_q1  <= '0;
    end else begin
      case ({push_ok, pop})
        2'b01: begin
          rx_q0  <= rx_q1;
          rx_cnt <= rx_cnt - 2'd1;
        end
        2'b10: begin
          if (rx_cnt == 2'd0) rx_q0 <= rx_nx;
          else                rx_q1 <= rx_nx;
          rx_cnt <= rx_cnt + 2'd1;
        end
        2'b11: begin
          if (rx_cnt == 2'd1) rx_q0 <= rx_nx;
          else begin
            rx_q0 <= rx_q1;
            rx_q1 <= rx_nx;
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_data   = rx_q0;
  assign flag_dre  = !tx_full;
  assign flag_txc  = txc_q;
  assign flag_rxc  = (rx_cnt != 2'd0);
  assign err_flags = 3'b000;
  assign sck       = cfg_cpol ^ sck_ph;
  assign mosi      = cfg_lsb_first ? tx_sh[0] : tx_sh[FRAME_W-1];
endmodule

module usart_spi_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_tx_en,
  input logic       wr_en,
  input logic       rd_en,
  input logic       flag_dre,
  input logic       flag_txc,
  input logic       flag_rxc,
  input logic [2:0] err_flags,
  input logic       sck,
  input logic       busy,
  input logic       tick,
  input logic       rx_push,
  input logic [1:0] rx_cnt
);
  // R10
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flags == 3'b000);

  // R6
  dre_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && cfg_tx_en && flag_dre |=> !flag_dre);

  // R3
  sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tick |=> $stable(sck));

  // R2
  tx_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_tx_en && !busy && flag_dre |=> !busy);

  // R8
  rx_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= 2'd2);

  // R8
  rx_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rx_cnt == 2'd1 && !rx_push |=> !flag_rxc);

  // R7
  txc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_txc) |-> !busy && flag_dre);
endmodule

bind usart_spi_master usart_spi_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_tx_en(cfg_tx_en), .wr_en(wr_en), .rd_en(rd_en),
  .flag_dre(flag_dre), .flag_txc(flag_txc), .flag_rxc(flag_rxc),
  .err_flags(err_flags), .sck(sck), .busy(busy), .tick(tick),
  .rx_push(rx_push), .rx_cnt(rx_cnt)
);

// File: tb/usart_spi_master_bench.sv
`timescale 1ns/1ps
module usart_spi_master_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 1'b1, rx_en = 1'b1, cpol = 1'b0, cpha = 1'b0, lsb = 1'b0;
  logic [11:0] baud = 12'd0;
  logic wr_en = 1'b0, rd_en = 1'b0, txc_clr = 1'b0, miso = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic flag_dre, flag_txc, flag_rxc, sck, mosi;
  logic [2:0] err_flags;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  usart_spi_master u_usart_spi_master (
    .clk(clk), .rst_n(rst_n), .cfg_tx_en(tx_en), .cfg_rx_en(rx_en),
    .cfg_cpol(cpol), .cfg_cpha(cpha), .cfg_lsb_first(lsb), .cfg_baud(baud),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .txc_clr(txc_clr), .flag_dre(flag_dre), .flag_txc(flag_txc),
    .flag_rxc(flag_rxc), .err_flags(err_flags), .sck(sck), .mosi(mosi),
    .miso(miso)
  );

  always #2 clk = ~clk;

  // slave device model
  logic [7:0] slv_bytes [0:7];
  logic [7:0] mosi_log [0:7];
  logic [7:0] s_rx = 8'h00;
  int slv_idx = 0, n_log = 0, s_edges = 0, s_drv = 0, sck_evts = 0;
  bit slv_on = 0;

  function automatic logic sbit(int i);
    if (slv_idx > 7) return 1'b0;
    return lsb ? slv_bytes[slv_idx][i] : slv_bytes[slv_idx][7-i];
  endfunction

  task automatic slv_prime();
    if (cpha) s_drv = 0;
    else begin
      miso = sbit(0);
      s_drv = 1;
    end
  endtask

  always @(sck) begin
    if (slv_on) begin
      if ((sck != cpol) == !cpha)
        s_rx = lsb ? {mosi, s_rx[7:1]} : {s_rx[6:0], mosi};
      else if (s_drv < 8) begin
        miso = sbit(s_drv);
        s_drv++;
      end
      s_edges++;
      sck_evts++;
      if (s_edges == 16) begin
        if (n_log < 8) mosi_log[n_log] = s_rx;
        n_log++;
        s_edges = 0;
        slv_idx++;
        slv_prime();
      end
    end
  end

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_mode(logic p, logic h, logic l, logic [11:0] b);
    slv_on = 0;
    @(negedge clk);
    cpol = p; cpha = h; lsb = l; baud = b;
    @(negedge clk);
    s_edges = 0; n_log = 0; slv_idx = 0; sck_evts = 0;
    slv_prime();
    slv_on = 1;
  endtask

  task automatic wr_byte(logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop_byte(string req, logic [7:0] exp);
    @(negedge clk);
    chk(req, {11'd0, flag_rxc}, 12'd1);
    chk(req, {4'd0, rd_data}, {4'd0, exp});
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_txc();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (flag_txc) break;
    end
  endtask

  task automatic clr_txc();
    @(negedge clk);
    txc_clr = 1'b1;
    @(negedge clk);
    txc_clr = 1'b0;
    @(negedge clk);
    chk("R7 txc clear", {11'd0, flag_txc}, 12'd0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 dre", {11'd0, flag_dre}, 12'd1);
    chk("R1 txc", {11'd0, flag_txc}, 12'd0);
    chk("R1 rxc", {11'd0, flag_rxc}, 12'd0);
    chk("R1 sck", {11'd0, sck}, {11'd0, cpol});
    chk("R10 err", {9'd0, err_flags}, 12'd0);
  endtask

  task automatic t_mode(logic p, logic h, logic l, logic [11:0] b,
                        logic [7:0] txb, logic [7:0] rxb);
    slv_bytes[0] = rxb;
    set_mode(p, h, l, b);
    chk("R3 idle level", {11'd0, sck}, {11'd0, p});
    wr_byte(txb);
    repeat (16 * (int'(b) + 1)) @(posedge clk);
    #1 chk("R3 txc not yet", {11'd0, flag_txc}, 12'd0);
    @(posedge clk);
    #1 chk("R3 txc timing", {11'd0, flag_txc}, 12'd1);
    chk("R3 sck transitions", sck_evts[11:0], 12'd16);
    chk("R3 sck back idle", {11'd0, sck}, {11'd0, p});
    chk("R4 R5 mosi byte", {4'd0, mosi_log[0]}, {4'd0, txb});
    pop_byte("R4 R5 miso byte", rxb);
    @(negedge clk);
    chk("R8 rxc after pop", {11'd0, flag_rxc}, 12'd0);
    chk("R10 err", {9'd0, err_flags}, 12'd0);
    clr_txc();
  endtask

  task automatic t_queue();
    slv_bytes[0] = 8'h81; slv_bytes[1] = 8'h42;
    set_mode(1'b0, 1'b0, 1'b0, 12'd1);
    wr_byte(8'h5A);
    for (int i = 0; i < 20 && !flag_dre; i++) @(negedge clk);
    chk("R6 dre after load", {11'd0, flag_dre}, 12'd1);
    wr_byte(8'hC3);
    chk("R6 dre full", {11'd0, flag_dre}, 12'd0);
    wr_byte(8'hFF);
    for (int i = 0; i < 2000 && n_log < 1; i++) @(negedge clk);
    chk("R7 no txc mid queue", {11'd0, flag_txc}, 12'd0);
    wait_txc();
    chk("R7 txc after queue", {11'd0, flag_txc}, 12'd1);
    repeat (80) @(negedge clk);
    chk("R6 frames sent", n_log[11:0], 12'd2);
    chk("R6 first byte", {4'd0, mosi_log[0]}, 12'h05A);
    chk("R6 queued byte", {4'd0, mosi_log[1]}, 12'h0C3);
    pop_byte("R8 order first", 8'h81);
    pop_byte("R8 order second", 8'h42);
    @(negedge clk);
    chk("R8 empty", {11'd0, flag_rxc}, 12'd0);
    clr_txc();
  endtask

  task automatic t_overflow();
    slv_bytes[0] = 8'h11; slv_bytes[1] = 8'h22; slv_bytes[2] = 8'h33;
    set_mode(1'b1, 1'b1, 1'b1, 12'd0);
    for (int k = 0; k < 3; k++) begin
      wr_byte(8'h60 + 8'(k));
      wait_txc();
      clr_txc();
    end
    pop_byte("R8 overflow keep oldest", 8'h11);
    pop_byte("R8 overflow keep second", 8'h22);
    @(negedge clk);
    chk("R8 third discarded", {11'd0, flag_rxc}, 12'd0);
  endtask

  task automatic t_rx_off();
    slv_bytes[0] = 8'hE7;
    set_mode(1'b0, 1'b1, 1'b0, 12'd2);
    rx_en = 1'b0;
    wr_byte(8'h96);
    wait_txc();
    chk("R9 tx still runs", {4'd0, mosi_log[0]}, 12'h096);
    chk("R9 no capture", {11'd0, flag_rxc}, 12'd0);
    rx_en = 1'b1;
    clr_txc();
  endtask

  task automatic t_tx_off();
    set_mode(1'b0, 1'b0, 1'b0, 12'd0);
    tx_en = 1'b0;
    wr_byte(8'h77);
    repeat (100) @(negedge clk);
    chk("R2 dre stays", {11'd0, flag_dre}, 12'd1);
    chk("R2 no clock", sck_evts[11:0], 12'd0);
    chk("R2 no txc", {11'd0, flag_txc}, 12'd0);
    tx_en = 1'b1;
    repeat (60) @(negedge clk);
    chk("R2 no late frame", sck_evts[11:0], 12'd0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    for (int m = 0; m < 8; m++)
      t_mode(m[0], m[1], m[2], 12'(m % 3), 8'h1D + 8'(m * 34), 8'hC6 - 8'(m * 19));
    t_queue();
    t_overflow();
    t_rx_off();
    t_tx_off();
    finish_run();
  end
endmodule